// File: doc/BRIEF.md
# Audio Transfer Start/Stop Controller

This block sequences both directions of an audio serial port. Software owns one run bit per direction, and that bit also acts as the direction's DMA request enable. One shared engine flag runs the transmit and receive serial engines together. The flag rises as soon as either direction asks to run. It falls only when both directions have been released. After the engines stop, the block clears both FIFOs on its own. Software can also clear either FIFO at any time through a clear register. The clear bits in that register stay at 1 while the clear is in progress and drop to 0 by themselves, so software can poll them.

Each FIFO drives a DMA request from its level and a programmable threshold. The serial bit engine is outside this block. It appears here as two valid/ready streams. The transmit engine drains words from the TX FIFO and the receive engine fills the RX FIFO. Back-pressure rules: a word moves only in a cycle where both valid and ready are 1. While `tx_out_valid` is 1 and `tx_out_ready` is 0, the data stays stable. `rx_in_ready` is 0 while the engines are stopped, the RX FIFO is full, or an RX clear is in progress. `DEPTH` must be a power of two, and `DW` must be at most 32.

Register addresses, with 3-bit `reg_addr`:
- 0 RUN: bit0 is TX run, bit1 is RX run. Read/write.
- 1 ENGINE: bit0 and bit1 both show the shared engine flag. Read-only.
- 2 CLEAR: bit0 is TX clear, bit1 is RX clear. Writing a 1 starts a clear. Reading shows which clears are pending.
- 3 THRESH: bits [7:0] hold the TX threshold and bits [15:8] hold the RX threshold. Both reset to 16.
- 4 TXDATA: write-only. Each write pushes one word.
- 5 RXDATA: read-only. A read with `reg_rd` high pops one word.
- 6 LEVEL: bits [7:0] hold the TX level and bits [15:8] hold the RX level.
- 7 STATUS: bit0 is the sticky TX overrun flag. Writing a 1 to it clears it.

Reads are combinational on `reg_addr`. Writes take effect at the clock edge.

Top module: `aud_xfer_ctrl`

## Requirements
- R1: The two RUN bits are written and read back independently, and each one enables only its own direction's DMA request.
- R2: When either RUN bit is set while no clear or stop is in progress, the ENGINE register reads 2'b11 one cycle after the RUN write has taken effect.
- R3: If one run bit is dropped while the other stays set, the engine flag stays at 1 and the stream of the remaining direction keeps flowing.
- R4: Once both RUN bits are 0, the engine flag falls one cycle later. In the cycle after that, both CLEAR bits read 1 and both FIFOs become empty.
- R5: A clear bit reads 1 for exactly CLR_CYCLES (4) cycles and then returns to 0 by itself. Writing CLEAR with only bit0 set empties only the TX FIFO and leaves the RX FIFO and the engine flag unchanged.
- R6: The engine flag never rises while any clear is pending. A run request made during a clear starts the engines once the clear has finished.
- R7: `tx_dma_req` is 1 exactly when TX run is 1 and the TX level is at or below the TX threshold.
- R8: `rx_dma_req` is 1 exactly when RX run is 1 and the RX level is above the RX threshold.
- R9: A read of RXDATA returns the oldest word and pops it, so words come out in arrival order. A read of an empty FIFO returns 0 and changes nothing.
- R10: The LEVEL register shows the current word count of both FIFOs, and THRESH resets to 16 in both fields.
- R11: A TXDATA write to a full TX FIFO is dropped and sets STATUS bit0. Writing 1 to STATUS bit0 clears the flag.
- R12: `tx_out_valid` is 1 only while the engines run, no TX clear is pending and the TX FIFO holds data. Words leave in write order, and the data holds while the stream is stalled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (pops RXDATA) |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data, combinational on reg_addr |
| tx_dma_req | output | 1 | TX DMA request |
| rx_dma_req | output | 1 | RX DMA request |
| tx_out_valid | output | 1 | TX word available to the serial engine |
| tx_out_ready | input | 1 | Serial engine accepts a TX word |
| tx_out_data | output | DW | TX word |
| rx_in_valid | input | 1 | Serial engine offers an RX word |
| rx_in_ready | output | 1 | Block accepts an RX word |
| rx_in_data | input | DW | RX word |

## Verification
Most internal faults show up at the ports within one to two cycles. A stuck engine flag shows in the ENGINE register and in the stream handshakes on the next sample. A stop sequence that is out of order shows a CLEAR bit set while ENGINE still reads 1, or the reverse. A wrong clear counter changes how many samples CLEAR reads 1, so the bench counts that window cycle by cycle. FIFO pointer or level faults appear as wrong word order on RXDATA or on the TX stream, as a wrong LEVEL value, or as a DMA request flipping one word too early or too late around the threshold.

// File: rtl/aud_xfer_pkg.sv
package aud_xfer_pkg;
  typedef enum logic [2:0] {
    REG_RUN    = 3'd0,
    REG_ENGINE = 3'd1,
    REG_CLEAR  = 3'd2,
    REG_THRESH = 3'd3,
    REG_TXDATA = 3'd4,
    REG_RXDATA = 3'd5,
    REG_LEVEL  = 3'd6,
    REG_STATUS = 3'd7
  } reg_sel_e;

  localparam int unsigned NUM_DIR = 2;
  localparam int unsigned DIR_TX  = 0;
  localparam int unsigned DIR_RX  = 1;
endpackage

// File: rtl/aud_fifo.sv
module aud_fifo #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 32,
  localparam int unsigned AW   = $clog2(DEPTH),
  localparam int unsigned LW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic          push,
  input  logic [DW-1:0] wdata,
  input  logic          pop,
  output logic [DW-1:0] rdata,
  output logic [LW-1:0] level,
  output logic          full,
  output logic          empty
);
  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wptr, rptr;
  logic push_ok, pop_ok;

  assign full    = (level == LW'(DEPTH));
  assign empty   = (level == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign rdata   = mem[rptr];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else if (flush) begin
      wptr  <= '0;
      rptr  <= '0;
      level <= '0;
    end else begin
      if (push_ok) wptr <= wptr + AW'(1);
      if (pop_ok)  rptr <= rptr + AW'(1);
      level <= level + LW'(push_ok) - LW'(pop_ok);
    end
  end

  always_ff @(posedge clk) begin
    if (push_ok && !flush) mem[wptr] <= wdata;
  end
endmodule

// File: rtl/aud_clr_timer.sv
module aud_clr_timer #(
  parameter int unsigned CLR_CYCLES = 4,
  localparam int unsigned CW        = $clog2(CLR_CYCLES + 1)
) (
  input  logic clk,
  input  logic rst_n,
  input  logic go,
  output logic pending,
  output logic start
);
  logic [CW-1:0] cnt;

  assign pending = (cnt != '0);
  assign start   = go && !pending;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt <= '0;
    else if (start)       cnt <= CW'(CLR_CYCLES);
    else if (pending)     cnt <= cnt - CW'(1);
  end
endmodule

// File: rtl/aud_xfer_seq.sv
module aud_xfer_seq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] run,
  input  logic       clr_busy,
  output logic       started,
  output logic       stop_go
);
  logic any_run;
  assign any_run = |run;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      started <= 1'b0;
      stop_go <= 1'b0;
    end else begin
      stop_go <= started && !any_run;
      if (started && !any_run)
        started <= 1'b0;
      else if (!started && any_run && !stop_go && !clr_busy)
        started <= 1'b1;
    end
  end
endmodule

// File: rtl/aud_xfer_ctrl.sv
module aud_xfer_ctrl
  import aud_xfer_pkg::*;
#(
  parameter int unsigned DW         = 32,
  parameter int unsigned DEPTH      = 32,
  parameter int unsigned CLR_CYCLES = 4,
  parameter int unsigned THR_RESET  = 16,
  localparam int unsigned LW        = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [2:0]    reg_addr,
  input  logic [31:0]   reg_wdata,
  output logic [31:0]   reg_rdata,
  output logic          tx_dma_req,
  output logic          rx_dma_req,
  output logic          tx_out_valid,
  input  logic          tx_out_ready,
  output logic [DW-1:0] tx_out_data,
  input  logic          rx_in_valid,
  output logic          rx_in_ready,
  input  logic [DW-1:0] rx_in_data
);
  logic [1:0]    run_q;
  logic [LW-1:0] thr_tx_q, thr_rx_q;
  logic          ovr_q;
  logic          started, stop_go;
  logic [1:0]    clr_go, clr_pend, clr_start;

  logic          wr_run, wr_clr, wr_thr, wr_txd, wr_stat, rd_rxd;
  logic [LW-1:0] tx_level, rx_level;
  logic          tx_full, tx_empty, rx_full, rx_empty;
  logic [DW-1:0] rx_head;
  logic          tx_pop, rx_push;

  assign wr_run  = reg_wr && (reg_addr == REG_RUN);
  assign wr_clr  = reg_wr && (reg_addr == REG_CLEAR);
  assign wr_thr  = reg_wr && (reg_addr == REG_THRESH);
  assign wr_txd  = reg_wr && (reg_addr == REG_TXDATA);
  assign wr_stat = reg_wr && (reg_addr == REG_STATUS);
  assign rd_rxd  = reg_rd && (reg_addr == REG_RXDATA);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q    <= '0;
      thr_tx_q <= LW'(THR_RESET);
      thr_rx_q <= LW'(THR_RESET);
      ovr_q    <= 1'b0;
    end else begin
      if (wr_run) run_q <= reg_wdata[1:0];
      if (wr_thr) begin
        thr_tx_q <= reg_wdata[LW-1:0];
        thr_rx_q <= reg_wdata[8+LW-1:8];
      end
      if (wr_txd && tx_full)           ovr_q <= 1'b1;
      else if (wr_stat && reg_wdata[0]) ovr_q <= 1'b0;
    end
  end

  aud_xfer_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .run      (run_q),
    .clr_busy (|clr_pend),
    .started  (started),
    .stop_go  (stop_go)
  );

  for (genvar g = 0; g < NUM_DIR; g++) begin : g_clr
    assign clr_go[g] = stop_go || (wr_clr && reg_wdata[g]);
    aud_clr_timer #(.CLR_CYCLES(CLR_CYCLES)) u_timer (
      .clk     (clk),
      .rst_n   (rst_n),
      .go      (clr_go[g]),
      .pending (clr_pend[g]),
      .start   (clr_start[g])
    );
  end

  assign tx_out_valid = started && !clr_pend[DIR_TX] && !tx_empty;
  assign tx_pop       = tx_out_valid && tx_out_ready;
  assign rx_in_ready  = started && !clr_pend[DIR_RX] && !rx_full;
  assign rx_push      = rx_in_valid && rx_in_ready;

  aud_fifo #(.DW(DW), .DEPTH(DEPTH)) u_txf (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (clr_start[DIR_TX]),
    .push  (wr_txd),
    .wdata (reg_wdata[DW-1:0]),
    .pop   (tx_pop),
    .rdata (tx_out_data),
    .level (tx_level),
    .full  (tx_full),
    .empty (tx_empty)
  );

  aud_fifo #(.DW(DW), .DEPTH(DEPTH)) u_rxf (
    .clk   (clk),
    .rst_n (rst_n),
    .flush (clr_start[DIR_RX]),
    .push  (rx_push),
    .wdata (rx_in_data),
    .pop   (rd_rxd),
    .rdata (rx_head),
    .level (rx_level),
    .full  (rx_full),
    .empty (rx_empty)
  );

  assign tx_dma_req = run_q[DIR_TX] && (tx_level <= thr_tx_q);
  assign rx_dma_req = run_q[DIR_RX] && (rx_level > thr_rx_q);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      REG_RUN:    reg_rdata[1:0] = run_q;
      REG_ENGINE: reg_rdata[1:0] = {started, started};
      REG_CLEAR:  reg_rdata[1:0] = clr_pend;
      REG_THRESH: reg_rdata      = {16'b0, 8'(thr_rx_q), 8'(thr_tx_q)};
      REG_RXDATA: reg_rdata      = rx_empty ? 32'b0 : 32'(rx_head);
      REG_LEVEL:  reg_rdata      = {16'b0, 8'(rx_level), 8'(tx_level)};
      REG_STATUS: reg_rdata[0]   = ovr_q;
      default:    reg_rdata      = '0;
    endcase
  end
endmodule

// File: rtl/aud_xfer_chk.sv
module aud_xfer_chk #(
  parameter int unsigned DW    = 32,
  parameter int unsigned DEPTH = 32,
  parameter int unsigned LW    = 6
) (
  input logic          clk,
  input logic          rst_n,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic [2:0]    reg_addr,
  input logic          started,
  input logic          stop_go,
  input logic [1:0]    run,
  input logic [1:0]    clr_pend,
  input logic [LW-1:0] tx_level,
  input logic [LW-1:0] rx_level,
  input logic          ovr,
  input logic          tx_out_valid,
  input logic          tx_out_ready,
  input logic [DW-1:0] tx_out_data,
  input logic          rx_in_valid,
  input logic          rx_in_ready
);
  assert_hold_run_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (started && (|run)) |=> started);

  assert_stop_clear_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(started) |=> (clr_pend == 2'b11));

  assert_no_start_in_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!started && (|clr_pend)) |=> !started);

  assert_rx_pop_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_rd && reg_addr == 3'd5 && rx_level != '0 && !reg_wr && !stop_go
     && !(rx_in_valid && rx_in_ready)) |=> (rx_level == $past(rx_level) - LW'(1)));

  assert_no_overflow_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_level == LW'(DEPTH) && reg_wr && reg_addr == 3'd4 && !stop_go
     && !(tx_out_valid && tx_out_ready)) |=> (tx_level == LW'(DEPTH) && ovr));

  assert_tx_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_out_valid && !tx_out_ready && (|run) && !(reg_wr && reg_addr == 3'd2))
      |=> (tx_out_valid && $stable(tx_out_data)));
endmodule

bind aud_xfer_ctrl aud_xfer_chk #(.DW(DW), .DEPTH(DEPTH), .LW(LW)) u_chk (
  .clk          (clk),
  .rst_n        (rst_n),
  .reg_wr       (reg_wr),
  .reg_rd       (reg_rd),
  .reg_addr     (reg_addr),
  .started      (started),
  .stop_go      (stop_go),
  .run          (run_q),
  .clr_pend     (clr_pend),
  .tx_level     (tx_level),
  .rx_level     (rx_level),
  .ovr          (ovr_q),
  .tx_out_valid (tx_out_valid),
  .tx_out_ready (tx_out_ready),
  .tx_out_data  (tx_out_data),
  .rx_in_valid  (rx_in_valid),
  .rx_in_ready  (rx_in_ready)
);

// File: tb/tb_aud_xfer_ctrl.sv
`timescale 1ns/1ps
module tb_aud_xfer_ctrl;
  localparam int DW = 32;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          reg_wr = 1'b0, reg_rd = 1'b0;
  logic [2:0]    reg_addr = '0;
  logic [31:0]   reg_wdata = '0;
  logic [31:0]   reg_rdata;
  logic          tx_dma_req, rx_dma_req;
  logic          tx_out_valid, rx_in_ready;
  logic          tx_out_ready = 1'b0, rx_in_valid = 1'b0;
  logic [DW-1:0] tx_out_data;
  logic [DW-1:0] rx_in_data = '0;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  aud_xfer_ctrl dut (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .tx_dma_req(tx_dma_req), .rx_dma_req(rx_dma_req),
    .tx_out_valid(tx_out_valid), .tx_out_ready(tx_out_ready), .tx_out_data(tx_out_data),
    .rx_in_valid(rx_in_valid), .rx_in_ready(rx_in_ready), .rx_in_data(rx_in_data)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic peek(input logic [2:0] a, output logic [31:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic pop_rx(output logic [31:0] d);
    reg_addr = 3'd5; reg_rd = 1'b1;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_rd = 1'b0;
  endtask

  task automatic settle();
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    peek(3'd0, d); chk("R1 run reset", d, 0);
    peek(3'd1, d); chk("R2 engine reset", d, 0);
    peek(3'd2, d); chk("R5 clear reset", d, 0);
    peek(3'd3, d); chk("R10 thresh reset", d, 32'h1010);
    peek(3'd6, d); chk("R10 level reset", d, 0);
    peek(3'd7, d); chk("R11 status reset", d, 0);
    chk("R7 txreq reset", tx_dma_req, 0);
    chk("R8 rxreq reset", rx_dma_req, 0);
    chk("R12 valid reset", tx_out_valid, 0);
  endtask

  task automatic t_enables();
    logic [31:0] d;
    wr(3'd0, 1);
    peek(3'd0, d); chk("R1 run tx only", d, 1);
    chk("R7 txreq with tx run", tx_dma_req, 1);
    chk("R1 rxreq off", rx_dma_req, 0);
    wr(3'd0, 3);
    peek(3'd0, d); chk("R1 run both", d, 3);
    wr(3'd0, 2);
    peek(3'd0, d); chk("R1 run rx only", d, 2);
    chk("R1 txreq dropped", tx_dma_req, 0);
    wr(3'd0, 0);
    settle();
  endtask

  task automatic t_start_stop();
    logic [31:0] d;
    int cnt;
    wr(3'd0, 1);
    peek(3'd1, d); chk("R2 engine one cycle later", d, 0);
    @(negedge clk);
    peek(3'd1, d); chk("R2 both engines start", d, 3);
    wr(3'd0, 3);
    wr(3'd0, 2);
    @(negedge clk);
    peek(3'd1, d); chk("R3 engines stay with rx", d, 3);
    chk("R3 rx stream ready", rx_in_ready, 1);
    wr(3'd0, 0);
    peek(3'd1, d); chk("R4 engine still up", d, 3);
    @(negedge clk);
    peek(3'd1, d); chk("R4 engine stopped", d, 0);
    peek(3'd2, d); chk("R4 clear after stop", d, 0);
    cnt = 0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      peek(3'd2, d);
      if (i == 0) chk("R4 both clears start", d, 3);
      if (d == 3) cnt++;
    end
    chk("R5 clear duration", cnt, 4);
    settle();
  endtask

  task automatic t_blocked();
    logic [31:0] e, c;
    int viol, seen, up;
    wr(3'd0, 1);
    @(negedge clk);
    wr(3'd0, 0);
    wr(3'd0, 1);
    viol = 0; seen = 0; up = 0;
    for (int i = 0; i < 12; i++) begin
      @(negedge clk);
      peek(3'd1, e); peek(3'd2, c);
      if (c != 0) seen = 1;
      if (e != 0 && c != 0) viol++;
      if (e == 3) up = 1;
    end
    chk("R6 no start during clear", viol, 0);
    chk("R6 clear seen", seen, 1);
    chk("R6 start after clear", up, 1);
    wr(3'd0, 0);
    settle();
  endtask

  task automatic t_tx_thresh();
    logic [31:0] d;
    wr(3'd3, 32'h0302);
    wr(3'd0, 1);
    wr(3'd4, 32'hA0);
    wr(3'd4, 32'hA1);
    peek(3'd6, d); chk("R10 tx level 2", d, 2);
    chk("R7 req at threshold", tx_dma_req, 1);
    wr(3'd4, 32'hA2);
    chk("R7 req above threshold", tx_dma_req, 0);
    chk("R12 valid", tx_out_valid, 1);
    chk("R12 head word", tx_out_data, 32'hA0);
    @(negedge clk);
    chk("R12 stalled hold", tx_out_data, 32'hA0);
    tx_out_ready = 1'b1;
    @(negedge clk);
    tx_out_ready = 1'b0;
    peek(3'd6, d); chk("R10 tx level after pop", d, 2);
    chk("R7 req back on", tx_dma_req, 1);
    chk("R12 order", tx_out_data, 32'hA1);
    tx_out_ready = 1'b1;
    repeat (2) @(negedge clk);
    tx_out_ready = 1'b0;
    chk("R12 valid low when empty", tx_out_valid, 0);
    wr(3'd0, 0);
    settle();
  endtask

  task automatic t_rx();
    logic [31:0] d;
    wr(3'd0, 2);
    @(negedge clk);
    for (int i = 0; i < 4; i++) begin
      rx_in_valid = 1'b1; rx_in_data = 32'hB0 + i;
      @(negedge clk);
      chk("R8 rx req vs level", rx_dma_req, (i + 1 > 3) ? 1 : 0);
    end
    rx_in_valid = 1'b0;
    peek(3'd6, d); chk("R10 rx level", d, 32'h0400);
    pop_rx(d); chk("R9 first word", d, 32'hB0);
    chk("R8 req off at threshold", rx_dma_req, 0);
    pop_rx(d); chk("R9 second word", d, 32'hB1);
    pop_rx(d); chk("R9 third word", d, 32'hB2);
    pop_rx(d); chk("R9 fourth word", d, 32'hB3);
    pop_rx(d); chk("R9 empty read", d, 0);
    peek(3'd6, d); chk("R9 level after empty read", d, 0);
    wr(3'd0, 0);
    settle();
  endtask

  task automatic t_overrun();
    logic [31:0] d;
    for (int i = 0; i < 32; i++) wr(3'd4, 32'hC00 + i);
    peek(3'd6, d); chk("R10 tx full level", d, 32);
    peek(3'd7, d); chk("R11 no overrun yet", d, 0);
    wr(3'd4, 32'hDEAD);
    peek(3'd6, d); chk("R11 level unchanged", d, 32);
    peek(3'd7, d); chk("R11 overrun set", d, 1);
    wr(3'd7, 1);
    peek(3'd7, d); chk("R11 overrun cleared", d, 0);
  endtask

  task automatic t_manual_clear();
    logic [31:0] d;
    int cnt;
    wr(3'd0, 2);
    @(negedge clk);
    for (int i = 0; i < 2; i++) begin
      rx_in_valid = 1'b1; rx_in_data = 32'hE0 + i;
      @(negedge clk);
    end
    rx_in_valid = 1'b0;
    wr(3'd2, 1);
    peek(3'd2, d); chk("R5 tx clear pending only", d, 1);
    peek(3'd6, d); chk("R5 tx flushed rx kept", d, 32'h0200);
    peek(3'd1, d); chk("R5 engines unaffected", d, 3);
    cnt = 1;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      peek(3'd2, d);
      if (d[0]) cnt++;
    end
    chk("R5 manual clear duration", cnt, 4);
    wr(3'd0, 0);
    settle();
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_enables();
    t_start_stop();
    t_blocked();
    t_tx_thresh();
    t_rx();
    t_overrun();
    t_manual_clear();
    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule